// File: doc/BRIEF.md
# I2C Slave Status and Interrupt Register

This block keeps the 32-bit read-only status word of an I2C slave channel. A slave protocol engine sends it single-cycle event pulses. These cover an addressed start or repeated start (with the index of the matched address), a stop, a general call with its kind, a received byte, a finished transmission, the transmit FIFO running empty or underflowing, a receive FIFO overflow, and a master read that found no data. The engine also drives a level that says it is busy. Each event sets a sticky flag, and the flag stays set until its own host-side clearing action occurs.

Each flag has its own clearing action. The host can read the status word, read the receive data register, write the transmit data register, flush the receive FIFO, or set the general-call acknowledge bit in its configuration. A stop or a reset-type general call clears some flags as well. The status word is a direct view of the flag registers. A read therefore returns the value held before any clear that the read itself triggers. When a set event and a clear action hit the same flag in one cycle, the set is kept.

Top module: `i2c_tgt_stat`

## Requirements
- R1: Out of reset the status word is 0x00000001 (only bit 0 set), and bits 31:15 always read zero.
- R2: Bit 14 is set one cycle after an addressed start pulse. It is cleared by a stop, or by a general call of kind 01.
- R3: Bit 13 is set one cycle after an addressed repeated start pulse. It is cleared by a stop, a status read, or a general call of kind 01.
- R4: Bits 12:11 load the 2-bit matched address index (0 to 3) on an addressed start or repeated start, and hold it at all other times.
- R5: Bit 10 is set by a stop that arrives while bit 14 or bit 13 is set. It is cleared by a status read.
- R6: A general call sets bit 7 and loads its kind into bits 9:8. The kinds are 00 none, 01 reset and program address, 10 program address, and 11 alternative ID. Only the configuration acknowledge strobe clears bit 7, and that strobe also returns bits 9:8 to 00.
- R7: Bit 5 is set when the master requests data and none is available. It is cleared by a status read.
- R8: Bit 4 is set on a receive FIFO overflow and cleared by a receive data read. Bit 3 is set on a received byte and cleared by a receive data read or a receive FIFO flush.
- R9: Bit 2 is set when a transmission finishes. Bit 1 is set on a transmit underflow. A transmit data write clears both.
- R10: Bit 0 is set by a transmit-empty event. It is cleared on the second transmit data write counted since it was last set. A new empty event restarts the count.
- R11: Bit 6 follows the engine busy input in the same cycle and is not sticky.
- R12: When a set event and a clear action for the same bit fall in one cycle, the bit ends up set.
- R13: During the cycle of a status read, the word shows the value from before the read's clearing effect. The clear is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_start_match_i | input | 1 | Pulse: start with address match |
| ev_rstart_match_i | input | 1 | Pulse: repeated start with address match |
| ev_match_id_i | input | 2 | Index of the matched address |
| ev_stop_i | input | 1 | Pulse: stop condition |
| ev_gcall_i | input | 1 | Pulse: general call received |
| ev_gc_kind_i | input | 2 | Kind of the general call |
| ev_rx_byte_i | input | 1 | Pulse: byte received |
| ev_rx_ovf_i | input | 1 | Pulse: receive FIFO overflow |
| ev_tx_done_i | input | 1 | Pulse: transmission finished |
| ev_tx_under_i | input | 1 | Pulse: transmit FIFO underflow |
| ev_tx_empty_i | input | 1 | Pulse: transmit FIFO became empty |
| ev_nodata_i | input | 1 | Pulse: master read with no data available |
| eng_busy_i | input | 1 | Level: engine busy |
| rd_stat_i | input | 1 | Host strobe: status word read |
| rd_rxdata_i | input | 1 | Host strobe: receive data read |
| wr_txdata_i | input | 1 | Host strobe: transmit data write |
| rx_flush_i | input | 1 | Host strobe: receive FIFO flush |
| gc_ack_i | input | 1 | Host strobe: general-call acknowledge bit set |
| stat_o | output | 32 | Status word |

## Verification
The case of interest is an engine event and a host strobe that target the same flag in the same cycle. Examples are a no-data event together with a status read, a transmit-empty event together with a transmit write, and a general call of kind 01 together with an addressed start. Directed steps drive each such pair at once and then expect the flag to stay set. A seeded random phase fires every pulse and strobe independently on every cycle, so these collisions recur thousands of times. That phase compares the whole status word each cycle against a bench model built from the per-bit rules.

// File: rtl/i2c_tgt_stat_pkg.sv
package i2c_tgt_stat_pkg;
   // Bit positions in the status word
   localparam int B_TXE    = 0;
   localparam int B_TXUF   = 1;
   localparam int B_TXDN   = 2;
   localparam int B_RXI    = 3;
   localparam int B_RXOV   = 4;
   localparam int B_NACK   = 5;
   localparam int B_BUSY   = 6;
   localparam int B_GCI    = 7;
   localparam int B_GCK_LO = 8;
   localparam int B_PSTOP  = 10;
   localparam int B_ID_LO  = 11;
   localparam int B_RSTA   = 13;
   localparam int B_STA    = 14;
   localparam int USED_W   = 15;
   localparam int ID_W     = 2;
   localparam int GCK_W    = 2;

   typedef enum logic [1:0] {
      GC_NONE     = 2'b00,
      GC_RST_PROG = 2'b01,
      GC_PROG     = 2'b10,
      GC_ALT      = 2'b11
   } gc_kind_e;
endpackage

// File: rtl/i2c_tgt_flag.sv
// One sticky flag. The SET_WINS parameter chooses the collision priority.
module i2c_tgt_flag #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set_i)      q_d = 1'b1;
            else if (clr_i) q_d = 1'b0;
            else            q_d = q_o;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr_i)      q_d = 1'b0;
            else if (set_i) q_d = 1'b1;
            else            q_d = q_o;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= RST_VAL;
      else         q_o <= q_d;
   end

   // Set wins over a clear in the same cycle
   assert_flag_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && (SET_WINS || !clr_i)) |=> q_o);
   assert_flag_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o);
   assert_flag_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/i2c_tgt_field.sv
// Multi-bit code register: load has priority over clear.
module i2c_tgt_field #(
   parameter int W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         clr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("i2c_tgt_field: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= '0;
      else if (load_i) q_o <= d_i;
      else if (clr_i)  q_o <= '0;
   end

   // Index (R4) and general call kind (R6) codes load and hold
   assert_field_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (q_o == $past(d_i)));
   assert_field_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !clr_i) |=> $stable(q_o));
   assert_field_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !load_i) |=> (q_o == '0));
endmodule

// File: rtl/i2c_tgt_txe.sv
// Transmit-empty flag: cleared after NWR transmit writes counted since the last set.
module i2c_tgt_txe #(
   parameter int NWR = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic wr_i,
   output logic q_o
);
   localparam int CW = (NWR < 2) ? 1 : $clog2(NWR);
   localparam logic [CW-1:0] LAST = CW'(NWR - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (NWR < 1) begin : g_bad_nwr
         $error("i2c_tgt_txe: NWR must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_o   <= 1'b1;
         cnt_q <= '0;
      end else if (set_i) begin
         q_o   <= 1'b1;
         cnt_q <= '0;
      end else if (q_o && wr_i) begin
         if (cnt_q == LAST) begin
            q_o   <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_txe_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);
   assert_txe_early_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o && wr_i && !set_i && (cnt_q != LAST)) |=> q_o);
   assert_txe_nowr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !wr_i) |=> $stable(q_o));
endmodule

// File: rtl/i2c_tgt_stat.sv
module i2c_tgt_stat
   import i2c_tgt_stat_pkg::*;
#(
   parameter int STAT_W     = 32,
   parameter int TXE_WRITES = 2,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ev_start_match_i,
   input  logic              ev_rstart_match_i,
   input  logic [1:0]        ev_match_id_i,
   input  logic              ev_stop_i,
   input  logic              ev_gcall_i,
   input  logic [1:0]        ev_gc_kind_i,
   input  logic              ev_rx_byte_i,
   input  logic              ev_rx_ovf_i,
   input  logic              ev_tx_done_i,
   input  logic              ev_tx_under_i,
   input  logic              ev_tx_empty_i,
   input  logic              ev_nodata_i,
   input  logic              eng_busy_i,
   input  logic              rd_stat_i,
   input  logic              rd_rxdata_i,
   input  logic              wr_txdata_i,
   input  logic              rx_flush_i,
   input  logic              gc_ack_i,
   output logic [STAT_W-1:0] stat_o
);
   generate
      if (STAT_W < USED_W) begin : g_bad_stat_w
         $error("i2c_tgt_stat: STAT_W too narrow for the status layout");
      end
   endgenerate

   logic             gc_rst;
   logic             addr_any;
   logic             q_sta, q_rsta, q_pstop, q_gci, q_nack;
   logic             q_rxov, q_rxi, q_txdn, q_txuf, q_txe;
   logic [ID_W-1:0]  id_q;
   logic [GCK_W-1:0] gck_q;

   assign gc_rst   = ev_gcall_i && (gc_kind_e'(ev_gc_kind_i) == GC_RST_PROG);
   assign addr_any = ev_start_match_i || ev_rstart_match_i;

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_sta (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_start_match_i),
      .clr_i(ev_stop_i || gc_rst), .q_o(q_sta));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_rsta (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_rstart_match_i),
      .clr_i(ev_stop_i || rd_stat_i || gc_rst), .q_o(q_rsta));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_pstop (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_stop_i && (q_sta || q_rsta)),
      .clr_i(rd_stat_i), .q_o(q_pstop));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_gci (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_gcall_i),
      .clr_i(gc_ack_i), .q_o(q_gci));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_nack (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_nodata_i),
      .clr_i(rd_stat_i), .q_o(q_nack));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_rxov (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_rx_ovf_i),
      .clr_i(rd_rxdata_i), .q_o(q_rxov));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_rxi (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_rx_byte_i),
      .clr_i(rd_rxdata_i || rx_flush_i), .q_o(q_rxi));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_txdn (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_tx_done_i),
      .clr_i(wr_txdata_i), .q_o(q_txdn));

   i2c_tgt_flag #(.RST_VAL(1'b0), .SET_WINS(SET_WINS)) u_txuf (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_tx_under_i),
      .clr_i(wr_txdata_i), .q_o(q_txuf));

   i2c_tgt_txe #(.NWR(TXE_WRITES)) u_txe (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev_tx_empty_i),
      .wr_i(wr_txdata_i), .q_o(q_txe));

   i2c_tgt_field #(.W(ID_W)) u_id (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(addr_any), .clr_i(1'b0),
      .d_i(ev_match_id_i), .q_o(id_q));

   i2c_tgt_field #(.W(GCK_W)) u_gck (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ev_gcall_i), .clr_i(gc_ack_i),
      .d_i(ev_gc_kind_i), .q_o(gck_q));

   always_comb begin
      stat_o                       = '0;
      stat_o[B_STA]                = q_sta;
      stat_o[B_RSTA]               = q_rsta;
      stat_o[B_ID_LO +: ID_W]      = id_q;
      stat_o[B_PSTOP]              = q_pstop;
      stat_o[B_GCK_LO +: GCK_W]    = gck_q;
      stat_o[B_GCI]                = q_gci;
      stat_o[B_BUSY]               = eng_busy_i;
      stat_o[B_NACK]               = q_nack;
      stat_o[B_RXOV]               = q_rxov;
      stat_o[B_RXI]                = q_rxi;
      stat_o[B_TXDN]               = q_txdn;
      stat_o[B_TXUF]               = q_txuf;
      stat_o[B_TXE]                = q_txe;
   end

   assert_sta_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_stop_i && !ev_start_match_i) |=> !stat_o[B_STA]);
   assert_rsta_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stat_i && !ev_rstart_match_i) |=> !stat_o[B_RSTA]);
   assert_pstop_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_stop_i && (stat_o[B_STA] || stat_o[B_RSTA])) |=> stat_o[B_PSTOP]);
   assert_gci_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_gcall_i && !gc_ack_i) |=> $stable(stat_o[B_GCI]));
   assert_nack_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stat_i && !ev_nodata_i) |=> !stat_o[B_NACK]);
   assert_rxi_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_flush_i && !ev_rx_byte_i) |=> !stat_o[B_RXI]);
   assert_txdn_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_txdata_i && !ev_tx_done_i) |=> !stat_o[B_TXDN]);
endmodule

// File: tb/i2c_tgt_stat_tb.sv
module i2c_tgt_stat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_sta = 0, ev_rsta = 0, ev_stop = 0, ev_gc = 0;
   logic [1:0]  ev_id = 0, ev_gck = 0;
   logic        ev_rxb = 0, ev_ovf = 0, ev_txd = 0, ev_tuf = 0, ev_txe = 0, ev_nd = 0;
   logic        busy = 0, rd_st = 0, rd_rx = 0, wr_tx = 0, flush = 0, gack = 0;
   logic [31:0] stat;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [14:0] m;      // model flags; bit 6 unused
   int          m_cnt;  // transmit writes since empty set

   always #5 clk = ~clk;

   i2c_tgt_stat dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .ev_start_match_i(ev_sta), .ev_rstart_match_i(ev_rsta), .ev_match_id_i(ev_id),
      .ev_stop_i(ev_stop), .ev_gcall_i(ev_gc), .ev_gc_kind_i(ev_gck),
      .ev_rx_byte_i(ev_rxb), .ev_rx_ovf_i(ev_ovf), .ev_tx_done_i(ev_txd),
      .ev_tx_under_i(ev_tuf), .ev_tx_empty_i(ev_txe), .ev_nodata_i(ev_nd),
      .eng_busy_i(busy), .rd_stat_i(rd_st), .rd_rxdata_i(rd_rx), .wr_txdata_i(wr_tx),
      .rx_flush_i(flush), .gc_ack_i(gack), .stat_o(stat));

   function automatic string tag_of(int b);
      case (b)
         0: return "R10";
         1, 2: return "R9";
         3, 4: return "R8";
         5: return "R7";
         6: return "R11";
         7, 8, 9: return "R6";
         10: return "R5";
         11, 12: return "R4";
         13: return "R3";
         14: return "R2";
         default: return "R1";
      endcase
   endfunction

   function automatic logic [31:0] view(logic [14:0] s, logic b);
      logic [31:0] v;
      v = {17'b0, s};
      v[6] = b;
      return v;
   endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmp_model();
      logic [31:0] e;
      e = view(m, busy);
      n_chk++;
      if (stat !== e) begin
         int fb = 0;
         for (int b = 31; b >= 0; b--) if (stat[b] !== e[b]) fb = b;
         n_bad++;
         $display("FAIL %s (model, bit %0d): actual=%h expected=%h", tag_of(fb), fb, stat, e);
      end
   endtask

   task automatic model_upd();
      logic [14:0] n;
      logic gcr;
      gcr = ev_gc && (ev_gck == 2'b01);
      n = m;
      if (ev_sta) n[14] = 1; else if (ev_stop || gcr) n[14] = 0;
      if (ev_rsta) n[13] = 1; else if (ev_stop || rd_st || gcr) n[13] = 0;
      if (ev_sta || ev_rsta) n[12:11] = ev_id;
      if (ev_stop && (m[14] || m[13])) n[10] = 1; else if (rd_st) n[10] = 0;
      if (ev_gc) n[9:8] = ev_gck; else if (gack) n[9:8] = 0;
      if (ev_gc) n[7] = 1; else if (gack) n[7] = 0;
      n[6] = 0;
      if (ev_nd) n[5] = 1; else if (rd_st) n[5] = 0;
      if (ev_ovf) n[4] = 1; else if (rd_rx) n[4] = 0;
      if (ev_rxb) n[3] = 1; else if (rd_rx || flush) n[3] = 0;
      if (ev_txd) n[2] = 1; else if (wr_tx) n[2] = 0;
      if (ev_tuf) n[1] = 1; else if (wr_tx) n[1] = 0;
      if (ev_txe) begin
         n[0] = 1; m_cnt = 0;
      end else if (m[0] && wr_tx) begin
         if (m_cnt + 1 >= 2) begin n[0] = 0; m_cnt = 0; end
         else m_cnt = m_cnt + 1;
      end
      m = n;
   endtask

   task automatic clr_in();
      {ev_sta, ev_rsta, ev_stop, ev_gc, ev_rxb, ev_ovf, ev_txd, ev_tuf, ev_txe, ev_nd} = '0;
      {rd_st, rd_rx, wr_tx, flush, gack} = '0;
      ev_id = 0; ev_gck = 0;
   endtask

   // Inputs were set after a falling edge; compare, clock, update model, release pulses
   task automatic step();
      #1 cmp_model();
      @(posedge clk);
      model_upd();
      @(negedge clk);
      clr_in();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1: watchdog expired actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd4711);
      m = 15'h0001; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stat, 32'h0000_0001, "R1 reset value");

      ev_sta = 1; ev_id = 2'd2; step();
      chk({31'b0, stat[14]}, 32'd1, "R2 start sets");
      chk({30'b0, stat[12:11]}, 32'd2, "R4 id loaded");

      ev_rsta = 1; ev_id = 2'd3; step();
      chk({30'b0, stat[12:11]}, 32'd3, "R4 id reloaded");
      rd_st = 1; #1 chk({31'b0, stat[13]}, 32'd1, "R13 read shows pre-clear");
      step();
      chk({31'b0, stat[13]}, 32'd0, "R3 read clears");
      chk({31'b0, stat[14]}, 32'd1, "R2 read leaves start flag");

      ev_stop = 1; step();
      chk({30'b0, stat[14], stat[10]}, 32'd1, "R5 stop after start / R2 cleared");
      rd_st = 1; step();
      chk({31'b0, stat[10]}, 32'd0, "R5 read clears");

      ev_sta = 1; step();
      ev_gc = 1; ev_gck = 2'b01; step();
      chk({29'b0, stat[14], stat[9:8]}, 32'd1, "R2 gc reset clears / R6 kind");
      rd_st = 1; step();
      chk({31'b0, stat[7]}, 32'd1, "R6 read does not clear gc flag");
      gack = 1; step();
      chk({29'b0, stat[7], stat[9:8]}, 32'd0, "R6 ack clears");
      ev_sta = 1; ev_gc = 1; ev_gck = 2'b01; step();
      chk({31'b0, stat[14]}, 32'd1, "R12 start beats gc reset");

      ev_nd = 1; rd_st = 1; step();
      chk({31'b0, stat[5]}, 32'd1, "R12 nodata beats read");
      rd_st = 1; step();
      chk({31'b0, stat[5]}, 32'd0, "R7 read clears");

      ev_rxb = 1; ev_ovf = 1; step();
      flush = 1; step();
      chk({30'b0, stat[4:3]}, 32'd2, "R8 flush clears rx only");
      rd_rx = 1; step();
      chk({30'b0, stat[4:3]}, 32'd0, "R8 read clears overflow");

      ev_txd = 1; ev_tuf = 1; step();
      wr_tx = 1; step();
      chk({29'b0, stat[2:0]}, 32'd1, "R9 write clears / R10 one write keeps empty");
      wr_tx = 1; step();
      chk({31'b0, stat[0]}, 32'd0, "R10 second write clears");
      ev_txe = 1; wr_tx = 1; step();
      chk({31'b0, stat[0]}, 32'd1, "R12 empty beats write");
      wr_tx = 1; step();
      chk({31'b0, stat[0]}, 32'd1, "R10 count restarted");
      wr_tx = 1; step();
      chk({31'b0, stat[0]}, 32'd0, "R10 cleared after two");

      busy = 1; #1 chk({31'b0, stat[6]}, 32'd1, "R11 busy live");
      busy = 0; #1 chk({31'b0, stat[6]}, 32'd0, "R11 busy drop");
      @(negedge clk);

      for (int i = 0; i < 4000; i++) begin
         ev_sta  = ($urandom % 8) == 0;
         ev_rsta = ($urandom % 8) == 0;
         ev_id   = 2'($urandom);
         ev_stop = ($urandom % 6) == 0;
         ev_gc   = ($urandom % 10) == 0;
         ev_gck  = 2'($urandom);
         ev_rxb  = ($urandom % 5) == 0;
         ev_ovf  = ($urandom % 9) == 0;
         ev_txd  = ($urandom % 6) == 0;
         ev_tuf  = ($urandom % 9) == 0;
         ev_txe  = ($urandom % 7) == 0;
         ev_nd   = ($urandom % 7) == 0;
         busy    = ($urandom % 2) == 0;
         rd_st   = ($urandom % 4) == 0;
         rd_rx   = ($urandom % 5) == 0;
         wr_tx   = ($urandom % 3) == 0;
         flush   = ($urandom % 9) == 0;
         gack    = ($urandom % 8) == 0;
         step();
      end
      #1 cmp_model();
      chk({15'b0, stat[31:15]}, 32'd0, "R1 upper bits zero");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule